// File: doc/BRIEF.md
# IR Pulse-Width Packet Receiver

This block recovers a three-bit command from a demodulated infrared line that idles high and pulls low to signal. Every symbol is one low interval, and only its length carries meaning. The block passes the line through a synchroniser and detects its edges. It counts the low time of each interval in ticks of `CLK_PER_TICK` clocks, where one tick stands for 100 µs. It then sorts that length into a header, a one, a zero or none of these.

A packet is a header, then the payload bits with the least significant bit first, then the complement of each payload bit in the same order. When all the checks hold, the block presents the payload on `pkt_data` and raises `pkt_valid` for a single clock. It then searches for a header again. Any malformed packet is dropped without a trace, and the receiver returns to header search.

Top module: `irpw_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `pkt_valid` is 0 and `pkt_data` is 0. A reset in the middle of a packet drops the partial packet, so the bits that follow it produce no strobe.
- R2: The length of a pulse is the number of whole ticks from the falling edge of `ir_rx_n` to the next rising edge. A header is accepted for a length of `HDR_TICKS` ± `TOL_TICKS` (29 to 31 by default).
- R3: While searching for a header, a pulse outside the header window (28 or 32 ticks, or a data-length pulse) is ignored and starts no packet.
- R4: A length of `ONE_TICKS` ± `TOL_TICKS` (9 to 11) is a 1 and a length of `ZERO_TICKS` ± `TOL_TICKS` (19 to 21) is a 0. The first data bit received is bit 0 of `pkt_data`.
- R5: After a header, a pulse that fits neither data window drops the packet, in both the data phase and the check phase. This includes a header-length pulse. A fresh header that follows at once is accepted.
- R6: Check bit i must be the inverse of data bit i. If any check bit equals its data bit, no strobe is produced.
- R7: `pkt_valid` is high for exactly one cycle per good packet. `pkt_data` keeps its value until the next good packet.
- R8: The tick count saturates at 2^`CNT_W`−1. A low pulse longer than that (94 ticks when `CNT_W`=6) never wraps into the header window.
- R9: After a good packet the receiver searches for a header again. Data-length pulses that follow produce nothing, and a following full packet is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_rx_n | input | 1 | Demodulated IR line, active low, asynchronous |
| pkt_valid | output | 1 | One-cycle strobe marking a decoded packet |
| pkt_data | output | NBITS | Last decoded payload, bit 0 received first |

## Verification
The bench builds the block with `CLK_PER_TICK`=4 and `CNT_W`=6. With these values a 30-tick header lasts about 120 clocks, so dozens of full packets fit in a short run. The 6-bit counter also saturates at 63 ticks, which makes an overlong pulse of 94 ticks easy to produce. Without saturation that pulse would wrap to exactly 30 and pass as a header, so the saturation rule can be checked directly. Every window edge (28, 29, 31, 32, 9, 11, 19, 21) is driven at a pulse length of tick·4+2 clocks, which sits in the middle of its tick.

// File: rtl/irpw_pkg.sv
package irpw_pkg;

    // Classification of one measured low interval.
    typedef enum logic [1:0] {
        SYM_NONE = 2'd0,
        SYM_HDR  = 2'd1,
        SYM_ONE  = 2'd2,
        SYM_ZERO = 2'd3
    } sym_e;

    // Receiver phase.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_DATA  = 2'd1,
        ST_CHECK = 2'd2
    } phase_e;

    // One classified pulse event.
    typedef struct packed {
        logic vld;
        sym_e sym;
    } pulse_t;

    // True when len lies within nom +/- tol (written to avoid underflow).
    function automatic logic in_window(input int unsigned len,
                                       input int unsigned nom,
                                       input int unsigned tol);
        return ((len + tol) >= nom) && (len <= (nom + tol));
    endfunction

    // Width of an index able to address n items (at least 1).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irpw_sync.sv
module irpw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Stage 0 samples the raw line; later stages re-time it.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= 1'b1;
                end else begin
                    if (g == 0) chain[g] <= din;
                    else        chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign fall = prev & ~lvl;
    assign rise = ~prev & lvl;

endmodule

// File: rtl/irpw_timer.sv
module irpw_timer #(
    parameter int unsigned CLK_PER_TICK = 5000,
    parameter int unsigned CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl,
    input  logic             fall,
    input  logic             rise,
    output logic [CNT_W-1:0] cnt,
    output logic             pulse_vld,
    output logic [CNT_W-1:0] pulse_len
);
    localparam int unsigned      PRE_W    = irpw_pkg::idx_width(CLK_PER_TICK);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_TICK - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [PRE_W-1:0] pre;
    logic             tick;

    generate
        if (CLK_PER_TICK == 1) begin : g_every_cycle
            assign tick = 1'b1;
        end else begin : g_divided
            assign tick = (pre == PRE_LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pre       <= '0;
            cnt       <= '0;
            pulse_vld <= 1'b0;
            pulse_len <= '0;
        end else begin
            pulse_vld <= rise;
            if (rise) pulse_len <= cnt;

            if (fall) begin
                pre <= '0;
                cnt <= '0;
            end else if (!lvl) begin
                if (tick) begin
                    pre <= '0;
                    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                end else begin
                    pre <= pre + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irpw_classify.sv
module irpw_classify
    import irpw_pkg::*;
#(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned HDR_TICKS  = 30,
    parameter int unsigned ONE_TICKS  = 10,
    parameter int unsigned ZERO_TICKS = 20,
    parameter int unsigned TOL_TICKS  = 1
) (
    input  logic             len_vld,
    input  logic [CNT_W-1:0] len,
    output pulse_t           ev
);
    logic is_hdr, is_one, is_zero;

    always_comb begin
        is_hdr  = in_window(32'(len), HDR_TICKS,  TOL_TICKS);
        is_one  = in_window(32'(len), ONE_TICKS,  TOL_TICKS);
        is_zero = in_window(32'(len), ZERO_TICKS, TOL_TICKS);

        ev.vld = len_vld;
        if (is_hdr)       ev.sym = SYM_HDR;
        else if (is_one)  ev.sym = SYM_ONE;
        else if (is_zero) ev.sym = SYM_ZERO;
        else              ev.sym = SYM_NONE;
    end

endmodule

// File: rtl/irpw_seq.sv
module irpw_seq
    import irpw_pkg::*;
#(
    parameter int unsigned NBITS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  pulse_t           ev,
    output logic             pkt_valid,
    output logic [NBITS-1:0] pkt_data
);
    localparam int unsigned      IDX_W    = idx_width(NBITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [NBITS-1:0] shadow;
    logic             is_bit;
    logic             bit_val;

    assign is_bit  = (ev.sym == SYM_ONE) || (ev.sym == SYM_ZERO);
    assign bit_val = (ev.sym == SYM_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_HUNT;
            idx       <= '0;
            shadow    <= '0;
            pkt_valid <= 1'b0;
            pkt_data  <= '0;
        end else begin
            pkt_valid <= 1'b0;
            if (ev.vld) begin
                case (phase)
                    ST_HUNT: begin
                        if (ev.sym == SYM_HDR) begin
                            phase <= ST_DATA;
                            idx   <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (is_bit) begin
                            shadow[idx] <= bit_val;
                            if (idx == IDX_LAST) begin
                                idx   <= '0;
                                phase <= ST_CHECK;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            phase <= ST_HUNT;
                            idx   <= '0;
                        end
                    end
                    ST_CHECK: begin
                        if (!is_bit || (bit_val == shadow[idx])) begin
                            phase <= ST_HUNT;
                            idx   <= '0;
                        end else if (idx == IDX_LAST) begin
                            phase     <= ST_HUNT;
                            idx       <= '0;
                            pkt_valid <= 1'b1;
                            pkt_data  <= shadow;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    default: begin
                        phase <= ST_HUNT;
                        idx   <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/irpw_rx.sv
module irpw_rx
    import irpw_pkg::*;
#(
    parameter int unsigned CLK_PER_TICK = 5000,
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned NBITS        = 3,
    parameter int unsigned HDR_TICKS    = 30,
    parameter int unsigned ONE_TICKS    = 10,
    parameter int unsigned ZERO_TICKS   = 20,
    parameter int unsigned TOL_TICKS    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ir_rx_n,
    output logic             pkt_valid,
    output logic [NBITS-1:0] pkt_data
);
    logic             sync_lvl;
    logic             sync_fall;
    logic             sync_rise;
    logic [CNT_W-1:0] tick_cnt;
    logic             pulse_vld;
    logic [CNT_W-1:0] pulse_len;
    pulse_t           pulse_ev;

    irpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ir_rx_n),
        .lvl  (sync_lvl),
        .fall (sync_fall),
        .rise (sync_rise)
    );

    irpw_timer #(.CLK_PER_TICK(CLK_PER_TICK), .CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .lvl       (sync_lvl),
        .fall      (sync_fall),
        .rise      (sync_rise),
        .cnt       (tick_cnt),
        .pulse_vld (pulse_vld),
        .pulse_len (pulse_len)
    );

    irpw_classify #(
        .CNT_W      (CNT_W),
        .HDR_TICKS  (HDR_TICKS),
        .ONE_TICKS  (ONE_TICKS),
        .ZERO_TICKS (ZERO_TICKS),
        .TOL_TICKS  (TOL_TICKS)
    ) u_classify (
        .len_vld (pulse_vld),
        .len     (pulse_len),
        .ev      (pulse_ev)
    );

    irpw_seq #(.NBITS(NBITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ev        (pulse_ev),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data)
    );

endmodule

// File: rtl/irpw_rx_chk.sv
module irpw_rx_chk #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned NBITS = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             lvl,
    input logic             fall,
    input logic [CNT_W-1:0] cnt,
    input logic             pulse_vld,
    input logic             pkt_valid,
    input logic [NBITS-1:0] pkt_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R2: every falling edge restarts the measurement from zero.
    p_clear_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        fall |=> (cnt == '0));

    // R2: the count is frozen while the line is high.
    p_frozen_high_r2: assert property (@(posedge clk) disable iff (rst)
        lvl |=> $stable(cnt));

    // R8: once at its ceiling, the count stays there until the next fall.
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        ((cnt == CNT_MAX) && !fall) |=> (cnt == CNT_MAX));

    // R7: the strobe never lasts two cycles.
    p_strobe_width_r7: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> !pkt_valid);

    // R7: the payload only moves together with the strobe.
    p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |-> $stable(pkt_data));

    // R9: a strobe always follows a measured pulse by one cycle.
    p_strobe_cause_r9: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> $past(pulse_vld));

endmodule

bind irpw_rx irpw_rx_chk #(.CNT_W(CNT_W), .NBITS(NBITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lvl       (sync_lvl),
    .fall      (sync_fall),
    .cnt       (tick_cnt),
    .pulse_vld (pulse_vld),
    .pkt_valid (pkt_valid),
    .pkt_data  (pkt_data)
);

// File: tb/tb_irpw_rx.sv
module tb_irpw_rx;
    localparam int CLK_PERIOD = 10;
    localparam int PER_TICK   = 4;
    localparam int CW         = 6;
    localparam int NB         = 3;
    localparam int GAP        = 20;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ir_rx_n = 1'b1;
    logic          pkt_valid;
    logic [NB-1:0] pkt_data;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    int vdata  = 0;
    int dbl    = 0;
    logic last_v = 1'b0;
    bit   done   = 1'b0;

    irpw_rx #(.CLK_PER_TICK(PER_TICK), .CNT_W(CW), .NBITS(NB)) dut (
        .clk       (clk),
        .rst       (rst),
        .ir_rx_n   (ir_rx_n),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (pkt_valid) begin
            vcount <= vcount + 1;
            vdata  <= int'(pkt_data);
            if (last_v) dbl <= dbl + 1;
        end
        last_v <= pkt_valid;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int ticks);
        @(negedge clk) ir_rx_n = 1'b0;
        repeat (ticks*PER_TICK + PER_TICK/2) @(negedge clk);
        ir_rx_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    function automatic int bt(input int b);
        return b ? 10 : 20;
    endfunction

    // Header, then data bits LSB first, then complements.
    task automatic frame(input int hdr, input int v);
        pulse(hdr);
        for (int i = 0; i < NB; i++) pulse(bt((v >> i) & 1));
        for (int i = 0; i < NB; i++) pulse(bt(((v >> i) & 1) ^ 1));
    endtask

    task automatic expect_pkts(input string tag, input int base, input int n, input int d);
        repeat (5) @(negedge clk);
        check({tag, " count"}, vcount - base, n);
        if (n > 0) check({tag, " data"}, vdata, d);
    endtask

    task automatic t_reset;
        check("R1 reset valid", int'(pkt_valid), 0);
        check("R1 reset data", int'(pkt_data), 0);
    endtask

    task automatic t_all_values;
        for (int v = 0; v < 8; v++) begin
            int b = vcount;
            frame(30, v);
            expect_pkts("R4 value", b, 1, v);
        end
    endtask

    task automatic t_header_edges;
        int b = vcount;
        frame(29, 3);
        expect_pkts("R2 header 29", b, 1, 3);
        b = vcount;
        frame(31, 6);
        expect_pkts("R2 header 31", b, 1, 6);
    endtask

    task automatic t_header_reject;
        int b = vcount;
        frame(28, 5);
        expect_pkts("R3 header 28", b, 0, 0);
        b = vcount;
        frame(32, 2);
        expect_pkts("R3 header 32", b, 0, 0);
        b = vcount;
        for (int i = 0; i < 6; i++) pulse(bt(i & 1));
        expect_pkts("R3 bits in hunt", b, 0, 0);
    endtask

    task automatic t_bit_edges;
        // value 2: bit0=0 (21), bit1=1 (9), bit2=0 (19); checks 1 (11), 0 (21), 1 (9)
        int b = vcount;
        pulse(30); pulse(21); pulse(9); pulse(19);
        pulse(11); pulse(21); pulse(9);
        expect_pkts("R4 window edges", b, 1, 2);
    endtask

    task automatic t_bad_pulse;
        int b = vcount;
        pulse(30); pulse(10); pulse(15);
        frame(30, 4);
        expect_pkts("R5 mid gap then header", b, 1, 4);
        b = vcount;
        pulse(30); pulse(10); pulse(30); pulse(20); pulse(10);
        pulse(20); pulse(10); pulse(20);
        expect_pkts("R5 header in data phase", b, 0, 0);
        b = vcount;
        pulse(30); pulse(10); pulse(10); pulse(10); pulse(20); pulse(22);
        pulse(20);
        expect_pkts("R5 bad check pulse", b, 0, 0);
        b = vcount;
        pulse(30); pulse(8);
        frame(30, 1);
        expect_pkts("R5 short 8 then header", b, 1, 1);
    endtask

    task automatic t_check_equal;
        // data 5 = 1,0,1 ; third check bit wrongly equal (1)
        int b = vcount;
        pulse(30); pulse(10); pulse(20); pulse(10);
        pulse(20); pulse(10); pulse(10);
        expect_pkts("R6 check equal", b, 0, 0);
        b = vcount;
        pulse(30); pulse(20); pulse(20); pulse(20);
        pulse(20); pulse(10); pulse(10);
        expect_pkts("R6 first check equal", b, 0, 0);
    endtask

    task automatic t_hold;
        int b = vcount;
        frame(30, 6);
        expect_pkts("R7 strobe", b, 1, 6);
        repeat (60) @(negedge clk);
        check("R7 data held", int'(pkt_data), 6);
        check("R7 single-cycle strobe", dbl, 0);
    endtask

    task automatic t_saturate;
        int b = vcount;
        pulse(94);
        for (int i = 0; i < NB; i++) pulse(bt((5 >> i) & 1));
        for (int i = 0; i < NB; i++) pulse(bt(((5 >> i) & 1) ^ 1));
        expect_pkts("R8 long pulse no wrap", b, 0, 0);
    endtask

    task automatic t_rehunt;
        int b = vcount;
        frame(30, 7);
        for (int i = 0; i < 6; i++) pulse(10);
        expect_pkts("R9 trailing bits", b, 1, 7);
        b = vcount;
        frame(30, 1);
        expect_pkts("R9 next packet", b, 1, 1);
    endtask

    task automatic t_mid_reset;
        int b = vcount;
        pulse(30); pulse(10); pulse(20);
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset clears data", int'(pkt_data), 0);
        rst = 1'b0;
        pulse(10); pulse(20); pulse(10); pulse(20);
        expect_pkts("R1 partial dropped", b, 0, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_all_values();
        t_header_edges();
        t_header_reject();
        t_bit_edges();
        t_bad_pulse();
        t_check_equal();
        t_hold();
        t_saturate();
        t_rehunt();
        t_mid_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule